// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the write controller of a byte-wide nonvolatile memory. It watches every byte write and looks for fixed address/data command sequences. One sequence arms software write protection and also unlocks a single page load. A longer sequence disarms protection. The protect flag is persistent: it changes only when the write controller reports the end of a write period and a sequence that completed earlier is still waiting to be applied.

For each write, one cycle later, the block reports a decision:
- whether the byte was consumed as a command step,
- whether it may be stored into the page buffer,
- whether the internal programming timer must run for the load.

A protected write that is not preceded by the unlock sequence still runs the timer, so the memory looks busy, but nothing is stored. Command steps must keep to the same byte-load timeout as page data. If the gap between writes exceeds `LOAD_TIMEOUT` cycles, the partial sequence is aborted and any open unlock window is closed.

Top module: `wp_cmd_guard`

## Requirements
- R1: In reset, and in every cycle with no write in the previous cycle, `dec_valid`, `dec_cmd`, `dec_store` and `dec_timer` are 0. After reset, `protect_on` is 0.
- R2: Each write produces its decision on the outputs in the cycle after `wr_valid`. With protection off and no sequence in progress, a write that is not a command step gives `dec_store`=1, `dec_timer`=1 and `dec_cmd`=0.
- R3: The arming sequence is three writes: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Each of these writes reports `dec_cmd`=1 and `dec_store`=0. Only the last one reports `dec_timer`=1.
- R4: After the arming sequence, `protect_on` stays 0 until the next `prog_done` pulse, even if no data byte follows. It reads 1 in the cycle after that pulse.
- R5: While `protect_on`=1, a write outside an unlock window reports `dec_store`=0 and `dec_timer`=1.
- R6: Once a complete arming or disarming sequence has been seen, following writes in the same load report `dec_store`=1 and `dec_timer`=1, whatever the state of `protect_on`.
- R7: The disarming sequence is six writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. All six report `dec_cmd`=1 and `dec_store`=0, and only the sixth reports `dec_timer`=1. `protect_on` falls to 0 after the next `prog_done`.
- R8: A write whose address (any of 15 bits) or data (any of 8 bits) differs from the expected next step returns the matcher to idle. That write is judged as an ordinary write (`dec_cmd`=0).
- R9: If the gap between two consecutive write strobes is more than `LOAD_TIMEOUT` cycles, a partial sequence is abandoned and an unlock window closes. A gap of exactly `LOAD_TIMEOUT` cycles keeps both.
- R10: `protect_on` changes only in the cycle after a `prog_done` pulse. A pulse with no completed sequence pending leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe for a byte write |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| prog_done | input | 1 | Pulse from the write controller at the end of a write period |
| dec_valid | output | 1 | A decision for the previous cycle's write is present |
| dec_cmd | output | 1 | The write was consumed as a command step |
| dec_store | output | 1 | The byte may be stored into the page buffer |
| dec_timer | output | 1 | The programming timer must run for this load |
| protect_on | output | 1 | Software write protection is active |

## Verification
A matcher left in the wrong state shows up on the very next write. Either a command step comes back with `dec_cmd`=0, or an ordinary byte comes back as a command. Sweeping a single flipped bit across every address and data position of each step exposes any comparator that ignores a bit. A wrong window or timeout count appears as `dec_store` one write too early or too late around the `LOAD_TIMEOUT` boundary. A corrupted pending flag stays hidden until the next `prog_done`, and then appears as a wrong `protect_on` in the following cycle.

// File: rtl/wp_pkg.sv
// Package: shared widths, matcher states and the command step table.
// Assumes byte-wide data and a 15-bit byte address space.
package wp_pkg;
    parameter int ADDR_W = 15;
    parameter int DATA_W = 8;

    // Number of distinct address/data comparisons the matcher needs
    localparam int STEP_N = 5;

    // Indices into the hit vector
    localparam int HIT_OPEN = 0;  // 0xAA @ 0x5555
    localparam int HIT_ACK  = 1;  // 0x55 @ 0x2AAA
    localparam int HIT_ARM  = 2;  // 0xA0 @ 0x5555
    localparam int HIT_EXT  = 3;  // 0x80 @ 0x5555
    localparam int HIT_FREE = 4;  // 0x20 @ 0x5555

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_G1   = 3'd1,
        SQ_G2   = 3'd2,
        SQ_D3   = 3'd3,
        SQ_D4   = 3'd4,
        SQ_D5   = 3'd5
    } seq_e;

    // Address compared for a given table entry
    function automatic logic [ADDR_W-1:0] step_addr(input int idx);
        return (idx == HIT_ACK) ? ADDR_W'(15'h2AAA) : ADDR_W'(15'h5555);
    endfunction

    // Data compared for a given table entry
    function automatic logic [DATA_W-1:0] step_data(input int idx);
        logic [DATA_W-1:0] v;
        case (idx)
            HIT_OPEN: v = DATA_W'(8'hAA);
            HIT_ACK:  v = DATA_W'(8'h55);
            HIT_ARM:  v = DATA_W'(8'hA0);
            HIT_EXT:  v = DATA_W'(8'h80);
            default:  v = DATA_W'(8'h20);
        endcase
        return v;
    endfunction
endpackage

// File: rtl/wp_step_match.sv
// Step comparators: one full-width address and data compare per table entry.
// Purely combinational; assumes inputs are stable while wr_valid is high.
module wp_step_match
    import wp_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STEP_N-1:0] hit
);
    for (genvar i = 0; i < STEP_N; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] A = step_addr(i);
        localparam logic [DATA_W-1:0] D = step_data(i);
        // Compare every address bit and every data bit of this entry
        assign hit[i] = (wr_addr == A) && (wr_data == D);
    end
endmodule

// File: rtl/wp_load_timer.sv
// Byte-load gap timer: counts idle cycles while a sequence or window is live.
// Assumes LOAD_TIMEOUT >= 2; expire pulses after LOAD_TIMEOUT idle cycles.
module wp_load_timer #(
    parameter int LOAD_TIMEOUT = 18750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic active,
    output logic expire
);
    localparam int CW = $clog2(LOAD_TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(LOAD_TIMEOUT - 1);

    logic [CW-1:0] idle_cnt;

    // Expiry fires on the idle cycle that completes the allowed gap
    assign expire = active && !wr_valid && (idle_cnt == LAST);

    // Idle counter: cleared by every write and by expiry, else counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (wr_valid || expire || !active) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wp_seq_fsm.sv
// Sequence matcher: walks the arming and disarming step orders.
// Assumes the window flag bypasses matching; a mismatch or expiry goes idle.
module wp_seq_fsm
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              window,
    input  logic              expire,
    input  logic [STEP_N-1:0] hit,
    output logic              cmd_hit,
    output logic              fire_arm,
    output logic              fire_free,
    output logic              busy
);
    seq_e state, state_nx;

    // Next state and per-write step classification
    always_comb begin
        state_nx  = state;
        cmd_hit   = 1'b0;
        fire_arm  = 1'b0;
        fire_free = 1'b0;
        if (expire) begin
            state_nx = SQ_IDLE;
        end else if (wr_valid && !window) begin
            state_nx = SQ_IDLE;
            case (state)
                SQ_IDLE: if (hit[HIT_OPEN]) begin state_nx = SQ_G1; cmd_hit = 1'b1; end
                SQ_G1:   if (hit[HIT_ACK])  begin state_nx = SQ_G2; cmd_hit = 1'b1; end
                SQ_G2: begin
                    if (hit[HIT_ARM]) begin
                        cmd_hit  = 1'b1;
                        fire_arm = 1'b1;
                    end else if (hit[HIT_EXT]) begin
                        state_nx = SQ_D3;
                        cmd_hit  = 1'b1;
                    end
                end
                SQ_D3:   if (hit[HIT_OPEN]) begin state_nx = SQ_D4; cmd_hit = 1'b1; end
                SQ_D4:   if (hit[HIT_ACK])  begin state_nx = SQ_D5; cmd_hit = 1'b1; end
                SQ_D5: begin
                    if (hit[HIT_FREE]) begin
                        cmd_hit   = 1'b1;
                        fire_free = 1'b1;
                    end
                end
                default: state_nx = SQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/wp_protect_reg.sv
// Persistent protect flag with a pending arm/disarm request.
// Assumes prog_done marks the end of a write period; the latest sequence wins.
module wp_protect_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_arm,
    input  logic fire_free,
    input  logic prog_done,
    output logic protect_on
);
    logic pend_arm, pend_free;

    // Apply pending request at end of write period, then record new requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            protect_on <= 1'b0;
            pend_arm   <= 1'b0;
            pend_free  <= 1'b0;
        end else begin
            if (prog_done) begin
                if (pend_arm)       protect_on <= 1'b1;
                else if (pend_free) protect_on <= 1'b0;
                pend_arm  <= 1'b0;
                pend_free <= 1'b0;
            end
            if (fire_arm) begin
                pend_arm  <= 1'b1;
                pend_free <= 1'b0;
            end else if (fire_free) begin
                pend_arm  <= 1'b0;
                pend_free <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wp_cmd_guard.sv
// Top: write-protect command sequence detector.
// Judges each byte write one cycle later: command step, storable, timer run.
// Assumes wr_valid is a single-cycle strobe per byte and prog_done a pulse.
module wp_cmd_guard
    import wp_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 18750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              dec_valid,
    output logic              dec_cmd,
    output logic              dec_store,
    output logic              dec_timer,
    output logic              protect_on
);
    logic [STEP_N-1:0] hit;
    logic cmd_hit, fire_arm, fire_free, seq_busy, expire;
    logic window;

    wp_step_match u_match (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit)
    );

    wp_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .window    (window),
        .expire    (expire),
        .hit       (hit),
        .cmd_hit   (cmd_hit),
        .fire_arm  (fire_arm),
        .fire_free (fire_free),
        .busy      (seq_busy)
    );

    wp_load_timer #(.LOAD_TIMEOUT(LOAD_TIMEOUT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .active   (seq_busy || window),
        .expire   (expire)
    );

    wp_protect_reg u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_arm   (fire_arm),
        .fire_free  (fire_free),
        .prog_done  (prog_done),
        .protect_on (protect_on)
    );

    // Unlock window: opened by a completed sequence, closed by the gap timer
    always_ff @(posedge clk) begin
        if (!rst_n)                      window <= 1'b0;
        else if (fire_arm || fire_free)  window <= 1'b1;
        else if (expire)                 window <= 1'b0;
    end

    // Per-write decision register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_cmd   <= 1'b0;
            dec_store <= 1'b0;
            dec_timer <= 1'b0;
        end else begin
            dec_valid <= wr_valid;
            dec_cmd   <= wr_valid && !window && cmd_hit;
            dec_store <= wr_valid && (window || (!cmd_hit && !protect_on));
            dec_timer <= wr_valid && (window || !cmd_hit || fire_arm || fire_free);
        end
    end
endmodule

// File: rtl/wp_guard_chk.sv
// Checker: port-level properties of the decision outputs and protect flag.
module wp_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic prog_done,
    input logic dec_valid,
    input logic dec_cmd,
    input logic dec_store,
    input logic dec_timer,
    input logic protect_on
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && !protect_on)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_cmd && !dec_store && !dec_timer)); // R1

    AST_ONE_CYCLE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_valid)) |-> dec_valid); // R2

    AST_STORE_RUNS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        dec_store |-> dec_timer); // R2

    AST_CMD_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_cmd |-> !dec_store); // R3

    AST_PROTECTED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_cmd) |-> dec_timer); // R5

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(protect_on)) |-> $past(prog_done)); // R10
endmodule

bind wp_cmd_guard wp_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .prog_done  (prog_done),
    .dec_valid  (dec_valid),
    .dec_cmd    (dec_cmd),
    .dec_store  (dec_store),
    .dec_timer  (dec_timer),
    .protect_on (protect_on)
);

// File: tb/wp_cmd_guard_bench.sv
module wp_cmd_guard_bench;
    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic dec_valid, dec_cmd, dec_store, dec_timer, protect_on;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wp_cmd_guard #(.LOAD_TIMEOUT(LIM)) u_wp_cmd_guard (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .dec_valid(dec_valid),
        .dec_cmd(dec_cmd), .dec_store(dec_store), .dec_timer(dec_timer),
        .protect_on(protect_on)
    );

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got v/c/s/t=%b expected %b", req, got, exp);
        end
    endtask

    task automatic chk_prot(input string req, input logic exp);
        n_vec++;
        if (protect_on !== exp) begin
            n_bad++;
            $display("FAIL %s protect_on got %b expected %b", req, protect_on, exp);
        end
    endtask

    // One write; the decision is sampled at the next falling edge
    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input logic c, input logic s, input logic t, input string req);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        chk(req, {dec_valid, dec_cmd, dec_store, dec_timer}, {1'b1, c, s, t});
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {dec_valid, dec_cmd, dec_store, dec_timer}, 4'b0000);
        chk_prot("R1", 1'b0);
        rst_n = 1'b1;
        idle(2);
        chk("R1", {dec_valid, dec_cmd, dec_store, dec_timer}, 4'b0000);

        // R2: unprotected ordinary writes over an address sweep
        for (int i = 0; i < 16; i++) begin
            wr(15'((i * 2053) & 15'h7FFF), 8'(i * 17 + 3), 1'b0, 1'b1, 1'b1, "R2");
        end
        idle(1);
        chk("R1", {dec_valid, dec_cmd, dec_store, dec_timer}, 4'b0000);

        // R8: single-bit address mismatch on every step position
        for (int b = 0; b < 15; b++) begin
            wr(15'h5555 ^ (15'd1 << b), 8'hAA, 1'b0, 1'b1, 1'b1, "R8");
            wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R3");
            wr(15'h2AAA ^ (15'd1 << b), 8'h55, 1'b0, 1'b1, 1'b1, "R8");
            wr(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, "R8");
        end
        // R8: single-bit data mismatch on the third step
        for (int b = 0; b < 8; b++) begin
            logic [7:0] d;
            logic branch;
            d = 8'hA0 ^ (8'd1 << b);
            branch = (d == 8'h80);
            wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R3");
            wr(15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, "R3");
            wr(15'h5555, d, branch, !branch, !branch, "R8");
            wr(15'h0000, 8'h00, 1'b0, 1'b1, 1'b1, "R8");
        end
        chk_prot("R8", 1'b0);

        // R3/R4: arming sequence, no data, takes effect only at prog_done
        wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R3");
        wr(15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, "R3");
        wr(15'h5555, 8'hA0, 1'b1, 1'b0, 1'b1, "R3");
        chk_prot("R4", 1'b0);
        idle(LIM);
        chk_prot("R4", 1'b0);
        done_pulse();
        chk_prot("R4", 1'b1);

        // R5: protected writes without the sequence
        for (int i = 0; i < 6; i++) begin
            wr(15'(i * 4099), 8'(8'h5A + i), 1'b0, 1'b0, 1'b1, "R5");
            idle(i);
        end

        // R6: unlock then page data stored while protected
        wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R6");
        wr(15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, "R6");
        wr(15'h5555, 8'hA0, 1'b1, 1'b0, 1'b1, "R6");
        for (int i = 0; i < 4; i++) wr(15'h0100 + 15'(i), 8'(i), 1'b0, 1'b1, 1'b1, "R6");
        wr(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, "R6");
        idle(LIM);
        wr(15'h0104, 8'h44, 1'b0, 1'b0, 1'b1, "R6");

        // R9: gap sweep between first and second steps
        for (int k = 0; k <= LIM + 1; k++) begin
            wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R9");
            idle(k);
            wr(15'h2AAA, 8'h55, k < LIM, 1'b0, !(k < LIM), "R9");
            idle(LIM);
        end
        // R9: window boundary
        wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R9");
        wr(15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, "R9");
        wr(15'h5555, 8'hA0, 1'b1, 1'b0, 1'b1, "R9");
        idle(LIM - 1);
        wr(15'h0200, 8'h11, 1'b0, 1'b1, 1'b1, "R9");
        idle(LIM);
        wr(15'h0201, 8'h22, 1'b0, 1'b0, 1'b1, "R9");

        // R10: pending arm applies (no change), then a pulse with nothing pending
        done_pulse();
        chk_prot("R10", 1'b1);
        done_pulse();
        chk_prot("R10", 1'b1);

        // R7: disarming sequence
        wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R7");
        wr(15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, "R7");
        wr(15'h5555, 8'h80, 1'b1, 1'b0, 1'b0, "R7");
        wr(15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0, "R7");
        wr(15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, "R7");
        wr(15'h5555, 8'h20, 1'b1, 1'b0, 1'b1, "R7");
        chk_prot("R7", 1'b1);
        idle(LIM);
        chk_prot("R7", 1'b1);
        done_pulse();
        chk_prot("R7", 1'b0);
        wr(15'h1234, 8'h99, 1'b0, 1'b1, 1'b1, "R2");
        done_pulse();
        chk_prot("R10", 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule